// File: doc/BRIEF.md
# Mask-Compressed Vector Element Sequencer

This block runs one element-wise integer add over a vector under a per-element enable mask. It holds the mask itself. On a run command it walks the mask and sends only the enabled element indices to a pipelined adder. A disabled element costs no cycle at all, so a run lasts in proportion to the number of set bits rather than to the vector length. Each issued index travels down the adder pipeline together with its sum and leaves on a write port with an enable. Disabled elements are never written.

The mask is changed by two commands. One command sets every bit. The other command loads the bits from a signed greater-than compare of a source vector against a scalar, reading one element per cycle through the first source port. Source operands come from an external register file that answers reads in the same cycle. A one-cycle `done` pulse closes every command.

Top module: `mask_skip_seq`

## Requirements
- R1: After reset `done` and `wr_en` are low and all mask bits are set, so a run that follows reset writes every element below the length.
- R2: An element whose mask bit is clear is never written by a run. Its destination keeps whatever it held.
- R3: A run or a compare only considers indices below the effective length, which is `len` clamped to NEL (default 64). Mask bits at or above the effective length are ignored by a run.
- R4: For each enabled element i, a run drives exactly one write with `wr_idx` = i and `wr_data` = (A[i] + B[i]) mod 2^DW. A[i] is read on port a and B[i] on port b, both with index i.
- R5: Let n be the number of enabled elements below the effective length, with start sampled at edge E0. For n > 0, `done` is first high after edge E0+n+DEPTH+1. For n = 0, `done` is first high after edge E0+1, and no write occurs.
- R6: Enabled elements are issued one per cycle in strictly ascending index order, so writes also come out in ascending order.
- R7: The set-all command sets every mask bit. `done` is high in the cycle right after the edge that samples the command.
- R8: The compare command reads element i on port a at cycles 1..L after the command edge (L = effective length). It sets mask bit i to 1 exactly when signed A[i] > signed `cmp_scalar`, for i < L, and leaves bits at or above L unchanged. `done` is first high after edge E0+max(L,1).
- R9: Commands are taken only while idle, with priority run > set-all > compare when several are high together. A command that is high while a run or compare is in progress is ignored.
- R10: `wr_en` is high only while a run is in progress, and `done` is never high in the same cycle as `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run the masked add over the vector |
| vlen | input | LW (7) | Vector length for a run or compare, clamped to NEL |
| mask_all | input | 1 | Set every mask bit |
| mask_cmp | input | 1 | Load the mask from a compare of vector A against `cmp_scalar` |
| cmp_scalar | input | DW (32) | Signed scalar for the compare |
| rd_a_idx | output | IW (6) | Read index for source port a |
| rd_b_idx | output | IW (6) | Read index for source port b |
| rd_a_data | input | DW (32) | Element read on port a, valid in the same cycle |
| rd_b_data | input | DW (32) | Element read on port b, valid in the same cycle |
| wr_en | output | 1 | Write enable for the destination |
| wr_idx | output | IW (6) | Destination element index |
| wr_data | output | DW (32) | Sum to write |
| done | output | 1 | One-cycle pulse at the end of a command |

## Verification
The assertions take for granted that the register file answers a read in the same cycle with no stall, and that the clamped length fits the mask. Under those conditions every issued index is in range and has its mask bit set. The assertions also assume the mask cannot change during a run, which holds because commands are ignored while busy. The stimulus drives commands only at negative edges, holds each one for one cycle, or for a few cycles when testing that busy commands are ignored, and picks random lengths from 0 up to above NEL so that clamping is exercised. Random compare scalars are kept in a narrow range, so the masks that result are neither always full nor always empty.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CMP  = 2'd2
  } msq_state_e;
endpackage

// File: rtl/msq_mask_reg.sv
module msq_mask_reg #(
  parameter int NEL = 64,
  parameter int IW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_all,
  input  logic           upd_en,
  input  logic [IW-1:0]  upd_idx,
  input  logic           upd_bit,
  output logic [NEL-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (set_all) mask_q <= '1;
    else if (upd_en)  mask_q[upd_idx] <= upd_bit;
  end
endmodule

// File: rtl/msq_picker.sv
module msq_picker #(
  parameter int NEL = 64,
  parameter int IW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NEL-1:0] load_vec,
  input  logic           take,
  output logic           pick_any,
  output logic [IW-1:0]  pick_idx
);
  logic [NEL-1:0] pend_q;

  // lowest set bit wins, so issue order is ascending
  function automatic logic [IW-1:0] lowest_set(input logic [NEL-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NEL - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign pick_any = |pend_q;
  assign pick_idx = lowest_set(pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= '0;
    else if (load) pend_q <= load_vec;
    else if (take) pend_q[pick_idx] <= 1'b0;
  end
endmodule

// File: rtl/msq_alu_pipe.sv
module msq_alu_pipe #(
  parameter int DEPTH = 3,
  parameter int DW    = 32,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [IW-1:0] in_idx,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_v,
  output logic [IW-1:0] out_idx,
  output logic [DW-1:0] out_data,
  output logic          any_v
);
  logic [DEPTH-1:0] v_q;
  logic [IW-1:0]    idx_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];

  function automatic logic [DW-1:0] add_wrap(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0; idx_q[0] <= '0; dat_q[0] <= '0;
        end else begin
          v_q[0]   <= in_v;
          idx_q[0] <= in_idx;
          dat_q[0] <= add_wrap(in_a, in_b);
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0; idx_q[g] <= '0; dat_q[g] <= '0;
        end else begin
          v_q[g]   <= v_q[g-1];
          idx_q[g] <= idx_q[g-1];
          dat_q[g] <= dat_q[g-1];
        end
      end
    end
  end

  assign out_v    = v_q[DEPTH-1];
  assign out_idx  = idx_q[DEPTH-1];
  assign out_data = dat_q[DEPTH-1];
  assign any_v    = |v_q;
endmodule

// File: rtl/mask_skip_seq.sv
module mask_skip_seq #(
  parameter int NEL   = 64,
  parameter int DW    = 32,
  parameter int DEPTH = 3,
  localparam int IW   = (NEL > 1) ? $clog2(NEL) : 1,
  localparam int LW   = $clog2(NEL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] vlen,
  input  logic          mask_all,
  input  logic          mask_cmp,
  input  logic [DW-1:0] cmp_scalar,
  output logic [IW-1:0] rd_a_idx,
  output logic [IW-1:0] rd_b_idx,
  input  logic [DW-1:0] rd_a_data,
  input  logic [DW-1:0] rd_b_data,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  import msq_pkg::*;

  function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] v);
    return (v > LW'(NEL)) ? LW'(NEL) : v;
  endfunction

  function automatic logic [NEL-1:0] below_len(input logic [LW-1:0] l);
    logic [NEL-1:0] m;
    for (int i = 0; i < NEL; i++) m[i] = (i < int'(l));
    return m;
  endfunction

  function automatic logic gt_signed(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  msq_state_e     state_q;
  logic [LW-1:0]  vl_q;
  logic [LW-1:0]  cnt_q;
  logic [NEL-1:0] mask_q;
  logic           pick_any;
  logic [IW-1:0]  pick_idx;
  logic           pipe_busy;

  // named events for the checker
  logic idle, go_run, go_all, go_cmp, issue, cmp_step, cmp_we, run_finish, cmp_finish, running;

  assign idle       = (state_q == ST_IDLE);
  assign running    = (state_q == ST_RUN);
  assign go_run     = idle && start;
  assign go_all     = idle && !start && mask_all;
  assign go_cmp     = idle && !start && !mask_all && mask_cmp;
  assign issue      = running && pick_any;
  assign cmp_step   = (state_q == ST_CMP);
  assign cmp_we     = cmp_step && (cnt_q < vl_q);
  assign cmp_finish = cmp_step && ((cnt_q + LW'(1)) >= vl_q);
  assign run_finish = running && !pick_any && !pipe_busy;

  assign rd_a_idx = cmp_step ? cnt_q[IW-1:0] : pick_idx;
  assign rd_b_idx = pick_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= run_finish || cmp_finish || go_all;
      if (go_run || go_cmp) vl_q <= clamp_len(vlen);
      if (go_cmp) cnt_q <= '0;
      else if (cmp_step && !cmp_finish) cnt_q <= cnt_q + LW'(1);
      unique case (state_q)
        ST_IDLE: if (go_run) state_q <= ST_RUN;
                 else if (go_cmp) state_q <= ST_CMP;
        ST_RUN:  if (run_finish) state_q <= ST_IDLE;
        ST_CMP:  if (cmp_finish) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  msq_mask_reg #(.NEL(NEL), .IW(IW)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_all(go_all),
    .upd_en(cmp_we), .upd_idx(cnt_q[IW-1:0]),
    .upd_bit(gt_signed(rd_a_data, cmp_scalar)), .mask_q(mask_q)
  );

  msq_picker #(.NEL(NEL), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .load(go_run),
    .load_vec(mask_q & below_len(clamp_len(vlen))),
    .take(issue), .pick_any(pick_any), .pick_idx(pick_idx)
  );

  msq_alu_pipe #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(issue), .in_idx(pick_idx),
    .in_a(rd_a_data), .in_b(rd_b_data),
    .out_v(wr_en), .out_idx(wr_idx), .out_data(wr_data), .any_v(pipe_busy)
  );
endmodule

// File: rtl/mask_skip_seq_chk.sv
module mask_skip_seq_chk #(
  parameter int NEL = 64,
  parameter int IW  = 6,
  parameter int LW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go_run,
  input logic           issue,
  input logic           running,
  input logic [IW-1:0]  rd_a_idx,
  input logic [IW-1:0]  rd_b_idx,
  input logic [LW-1:0]  vl_q,
  input logic [NEL-1:0] mask_q,
  input logic           wr_en,
  input logic           done
);
  logic [IW-1:0] last_q;
  logic          seen_q;
  logic [LW:0]   iss_n, wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n || go_run) begin
      seen_q <= 1'b0; last_q <= '0; iss_n <= '0; wr_n <= '0;
    end else begin
      if (issue) begin
        seen_q <= 1'b1; last_q <= rd_b_idx; iss_n <= iss_n + 1'b1;
      end
      if (wr_en) wr_n <= wr_n + 1'b1;
    end
  end

  // R3
  in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (LW'(rd_b_idx) < vl_q));
  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> mask_q[rd_b_idx]);
  // R6
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && seen_q) |-> (rd_b_idx > last_q));
  // R4
  same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (rd_a_idx == rd_b_idx));
  // R4
  wr_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_n < iss_n));
  // R10
  wr_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> running);
  // R10
  done_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);
endmodule

bind mask_skip_seq mask_skip_seq_chk #(.NEL(NEL), .IW(IW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_run(go_run), .issue(issue), .running(running),
  .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .vl_q(vl_q), .mask_q(mask_q),
  .wr_en(wr_en), .done(done)
);

// File: tb/mask_skip_seq_bench.sv
module mask_skip_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NEL = 64;
  localparam int DW = 32;
  localparam int DEPTH = 3;
  localparam int IW = 6;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mask_all = 1'b0, mask_cmp = 1'b0;
  logic [LW-1:0] vlen = '0;
  logic [DW-1:0] cmp_scalar = '0;
  logic [IW-1:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic wr_en, done;

  logic [DW-1:0] va [NEL];
  logic [DW-1:0] vb [NEL];
  logic [DW-1:0] vw [NEL];
  logic          emask [NEL];

  int total = 0, bad = 0;
  int wr_n = 0, last_wr = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_a_data = va[rd_a_idx];
  assign rd_b_data = vb[rd_b_idx];

  mask_skip_seq #(.NEL(NEL), .DW(DW), .DEPTH(DEPTH)) u_mask_skip_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mask_all(mask_all),
    .mask_cmp(mask_cmp), .cmp_scalar(cmp_scalar), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done)
  );

  function automatic int eff_len(input int l);
    return (l > NEL) ? NEL : l;
  endfunction

  function automatic logic [DW-1:0] sentinel(input int i);
    return 32'hC0DE_0000 + DW'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // destination model, with order and done/wr overlap checks
  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      vw[wr_idx] <= wr_data;
      chk(int'(wr_idx) > last_wr, "R6 write order", int'(wr_idx), last_wr + 1);
      chk(!done, "R10 done with write", 1, 0);
      last_wr = int'(wr_idx);
      wr_n++;
    end
  end

  task automatic send(input bit s, input bit ma, input bit mc, input int len,
                      input logic [DW-1:0] sc, input int hold, output int cyc);
    @(negedge clk);
    start = s; mask_all = ma; mask_cmp = mc; vlen = LW'(len); cmp_scalar = sc;
    @(negedge clk);
    cyc = 0;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      cyc++;
    end
    start = 0; mask_all = 0; mask_cmp = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_run(input int len, input bit noisy);
    int cyc, n, l;
    l = eff_len(len);
    n = 0;
    for (int i = 0; i < NEL; i++) vw[i] = sentinel(i);
    for (int i = 0; i < l; i++) if (emask[i]) n++;
    wr_n = 0; last_wr = -1;
    // noisy: set-all and compare held high with start and for 2 busy cycles (R9)
    send(1'b1, noisy, noisy, len, 32'h7FFF_FFFF, noisy ? 2 : 0, cyc);
    chk(cyc == ((n == 0) ? 1 : n + DEPTH + 1), "R5 run cycles", cyc, (n == 0) ? 1 : n + DEPTH + 1);
    chk(wr_n == n, "R2 write count", wr_n, n);
    for (int i = 0; i < NEL; i++) begin
      logic [DW-1:0] e;
      e = (i < l && emask[i]) ? va[i] + vb[i] : sentinel(i);
      chk(vw[i] == e, (i >= l) ? "R3 beyond length" : (emask[i] ? "R4 sum" : "R2 masked"),
          int'(vw[i]), int'(e));
    end
  endtask

  task automatic do_cmp(input int len, input logic [DW-1:0] sc);
    int cyc, l;
    l = eff_len(len);
    send(1'b0, 1'b0, 1'b1, len, sc, 0, cyc);
    chk(cyc == ((l > 1) ? l : 1), "R8 compare cycles", cyc, (l > 1) ? l : 1);
    for (int i = 0; i < l; i++) emask[i] = ($signed(va[i]) > $signed(sc));
  endtask

  task automatic do_all();
    int cyc;
    send(1'b0, 1'b1, 1'b0, 0, '0, 0, cyc);
    chk(cyc == 0, "R7 set-all done", cyc, 0);
    for (int i = 0; i < NEL; i++) emask[i] = 1'b1;
  endtask

  task automatic fill();
    for (int i = 0; i < NEL; i++) begin
      va[i] = $urandom();
      vb[i] = $urandom();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    fill();
    for (int i = 0; i < NEL; i++) emask[i] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !wr_en, "R1 reset outputs", int'({done, wr_en}), 0);
    do_run(64, 0);                       // R1 full mask after reset
    do_cmp(64, 32'd0);                   // R8 compare, half the signs
    fill();
    do_run(64, 0);
    do_run(0, 0);                        // R5 empty length
    do_cmp(64, 32'h7FFF_FFFF);           // R8 nothing greater
    do_run(64, 0);                       // R5 zero enabled
    do_all();                            // R7
    do_cmp(10, 32'd0);                   // R8 bits 10..63 stay set
    do_run(100, 0);                      // R3 clamp to 64
    do_cmp(0, 32'd0);                    // R8 zero length
    do_run(20, 0);
    do_all();
    for (int i = 0; i < NEL; i++) va[i] = 32'hFFFF_FF00;
    va[63] = 32'd5;
    do_cmp(64, 32'd0);                   // only element 63 enabled
    do_run(64, 0);                       // R5 single element at the top
    do_run(63, 0);                       // R3 bit 63 beyond length
    do_cmp(64, 32'h8000_0000);
    do_run(40, 1);                       // R9 priority and busy commands
    do_run(40, 0);                       // R9 mask unchanged
    for (int k = 0; k < 14; k++) begin
      int op;
      op = int'($urandom_range(0, 2));
      fill();
      if (op == 0) do_cmp(int'($urandom_range(0, 70)), $urandom_range(0, 32'h4000_0000) - 32'h2000_0000);
      else if (op == 1) do_all();
      do_run(int'($urandom_range(0, 80)), k[0]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule